// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the byte-wide programming port of an eight-line programmable interrupt controller. Software talks to it through two byte addresses selected by a single address bit. Each write is decoded in one of two ways. On the low address, data bit 4 separates a start-of-setup byte from a run-time command byte. On the high address, an internal step counter decides whether the byte is the vector base, the cascade map, the mode byte or, when no setup is in progress, the line mask.

The block holds the resulting configuration: line mask, vector base, cascade map, edge/level trigger, single/cascade mode and automatic end-of-interrupt. It presents these as plain outputs to a separate priority core. It turns end-of-interrupt commands into one-cycle pulses that carry a specific/nonspecific flag and a line number. It reads back either the request or the in-service register, both of which the core supplies, or the mask. The parameter `IS_MASTER` selects whether the third setup byte is stored as a map of lines with slaves attached or as a 3-bit slave identity. Every pin is a plain control or status pin: writes, reads and pulses are accepted or issued every cycle with no back-pressure.

Top module: `pic_cmd_seq`

## Requirements
- R1: After reset, the mask, vector base, cascade map, trigger and mode outputs and auto-EOI are all 0. The step counter is idle, and reads of address 0 select the request register.
- R2: A write to address 0 with data bit 4 set starts setup. It clears the mask, sets edge mode from bit 3 (1 = edge), sets single mode from bit 1 (1 = single, 0 = cascade), records from bit 0 whether a mode byte will follow, and clears auto-EOI when bit 0 is 0.
- R3: The next write to address 1 sets the vector base to the data with bits 2:0 cleared. In single mode setup ends there and the cascade map becomes 0; in cascade mode the cascade step follows.
- R4: In the cascade step, a master (`IS_MASTER`=1) stores all 8 data bits as the cascade map, and a slave stores only data bits 2:0 with the upper bits 0.
- R5: After the cascade step, setup ends unless a mode byte was announced. In the mode step, data bit 1 sets auto-EOI, bits 4, 3, 2 and 0 have no effect, and setup always ends.
- R6: When no setup is in progress, a write to address 1 loads the mask with all 8 data bits.
- R7: A write to address 0 with bits 4:3 = 00 is an EOI command word. Bits 7:5 = 001 issue a nonspecific EOI (`eoi_specific`=0, line 0). Bits 7:5 = 011 issue a specific EOI on the line in bits 2:0. The pulse is high for exactly the one cycle after the write edge. All other codes issue nothing.
- R8: A write to address 0 with bits 4:3 = 01 is a read-select word. When bit 1 is 1, bit 0 selects the request register (1) or the in-service register (0) for reads of address 0. When bit 1 is 0, the selection is unchanged.
- R9: `rdata` is registered. It takes its new value at the clock edge where `rd_en` is high and holds it otherwise. Address 0 returns the selected request or in-service register, and address 1 returns the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Register address bit |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| req_bits | input | 8 | Request register from the priority core |
| isr_bits | input | 8 | In-service register from the priority core |
| mask_o | output | 8 | Line mask |
| vec_base_o | output | 8 | Vector base, bits 2:0 zero |
| cascade_o | output | 8 | Cascade map (master) or slave identity |
| edge_mode_o | output | 1 | 1 = edge triggered, 0 = level |
| single_mode_o | output | 1 | 1 = single controller, 0 = cascaded |
| auto_eoi_o | output | 1 | Automatic end-of-interrupt enabled |
| eoi_valid | output | 1 | One-cycle EOI command pulse |
| eoi_specific | output | 1 | 1 = specific EOI, 0 = nonspecific |
| eoi_line | output | 3 | Line of a specific EOI |

## Verification
The checker watches on every cycle that each EOI pulse follows a command-word write, that a setup start leaves the mask cleared, and that the vector base, trigger mode, auto-EOI and read data change only after the write or read that may change them. The meaning of each byte written to address 1 can only be shown by the bench's directed sequences. This covers single versus cascade setup, whether a mode byte was announced, and master versus slave storage of the cascade byte. The bench also covers which EOI codes are no-ops and how the read selection persists.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_VEC  = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_state_t;

  localparam logic [2:0] EOI_NONSPEC = 3'b001;
  localparam logic [2:0] EOI_SPEC    = 3'b011;
endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode #(
  parameter int DW = 8
) (
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic          setup_wr,
  output logic          eoi_word_wr,
  output logic          rdsel_wr,
  output logic          hi_wr
);
  always_comb begin
    setup_wr    = wr_en && !addr && wdata[4];
    eoi_word_wr = wr_en && !addr && (wdata[4:3] == 2'b00);
    rdsel_wr    = wr_en && !addr && (wdata[4:3] == 2'b01);
    hi_wr       = wr_en && addr;
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter int DW        = 8,
  parameter int LW        = 3,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          setup_wr,
  input  logic          rdsel_wr,
  input  logic          hi_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] vec_q,
  output logic [DW-1:0] casc_q,
  output logic          edge_q,
  output logic          single_q,
  output logic          auto_q,
  output logic          sel_req_q
);
  seq_state_t    state_q;
  logic          mode_next_q;
  logic [DW-1:0] casc_in;

  generate
    if (IS_MASTER) begin : g_master
      assign casc_in = wdata;
    end else begin : g_slave
      assign casc_in = {{(DW-LW){1'b0}}, wdata[LW-1:0]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= SEQ_IDLE;
      mask_q      <= '0;
      vec_q       <= '0;
      casc_q      <= '0;
      edge_q      <= 1'b0;
      single_q    <= 1'b0;
      auto_q      <= 1'b0;
      mode_next_q <= 1'b0;
      sel_req_q   <= 1'b1;
    end else begin
      if (setup_wr) begin
        mask_q      <= '0;
        edge_q      <= wdata[3];
        single_q    <= wdata[1];
        mode_next_q <= wdata[0];
        if (!wdata[0]) auto_q <= 1'b0;
        state_q     <= SEQ_VEC;
      end else if (hi_wr) begin
        case (state_q)
          SEQ_IDLE: mask_q <= wdata;
          SEQ_VEC: begin
            vec_q <= {wdata[DW-1:LW], {LW{1'b0}}};
            if (single_q) begin
              casc_q  <= '0;
              state_q <= SEQ_IDLE;
            end else begin
              state_q <= SEQ_CASC;
            end
          end
          SEQ_CASC: begin
            casc_q  <= casc_in;
            state_q <= mode_next_q ? SEQ_MODE : SEQ_IDLE;
          end
          default: begin
            auto_q  <= wdata[1];
            state_q <= SEQ_IDLE;
          end
        endcase
      end
      if (rdsel_wr && wdata[1]) sel_req_q <= wdata[0];
    end
  end
endmodule

// File: rtl/pic_eoi_gen.sv
module pic_eoi_gen
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eoi_word_wr,
  input  logic [DW-1:0] wdata,
  output logic          eoi_valid,
  output logic          eoi_specific,
  output logic [LW-1:0] eoi_line
);
  logic [2:0] code;
  assign code = wdata[7:5];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoi_valid    <= 1'b0;
      eoi_specific <= 1'b0;
      eoi_line     <= '0;
    end else begin
      eoi_valid    <= 1'b0;
      eoi_specific <= 1'b0;
      eoi_line     <= '0;
      if (eoi_word_wr && code == EOI_NONSPEC) begin
        eoi_valid <= 1'b1;
      end else if (eoi_word_wr && code == EOI_SPEC) begin
        eoi_valid    <= 1'b1;
        eoi_specific <= 1'b1;
        eoi_line     <= wdata[LW-1:0];
      end
    end
  end
endmodule

// File: rtl/pic_readback.sv
module pic_readback #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          addr,
  input  logic          sel_req,
  input  logic [DW-1:0] req_bits,
  input  logic [DW-1:0] isr_bits,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= addr ? mask : (sel_req ? req_bits : isr_bits);
  end
endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq #(
  parameter int LW        = 3,
  parameter bit IS_MASTER = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 addr,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [(1<<LW)-1:0]   wdata,
  output logic [(1<<LW)-1:0]   rdata,
  input  logic [(1<<LW)-1:0]   req_bits,
  input  logic [(1<<LW)-1:0]   isr_bits,
  output logic [(1<<LW)-1:0]   mask_o,
  output logic [(1<<LW)-1:0]   vec_base_o,
  output logic [(1<<LW)-1:0]   cascade_o,
  output logic                 edge_mode_o,
  output logic                 single_mode_o,
  output logic                 auto_eoi_o,
  output logic                 eoi_valid,
  output logic                 eoi_specific,
  output logic [LW-1:0]        eoi_line
);
  localparam int DW = 1 << LW;

  logic setup_wr, eoi_word_wr, rdsel_wr, hi_wr, sel_req;

  pic_cmd_decode #(.DW(DW)) u_dec (
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .setup_wr(setup_wr), .eoi_word_wr(eoi_word_wr),
    .rdsel_wr(rdsel_wr), .hi_wr(hi_wr)
  );

  pic_init_seq #(.DW(DW), .LW(LW), .IS_MASTER(IS_MASTER)) u_seq (
    .clk(clk), .rst_n(rst_n), .setup_wr(setup_wr), .rdsel_wr(rdsel_wr),
    .hi_wr(hi_wr), .wdata(wdata), .mask_q(mask_o), .vec_q(vec_base_o),
    .casc_q(cascade_o), .edge_q(edge_mode_o), .single_q(single_mode_o),
    .auto_q(auto_eoi_o), .sel_req_q(sel_req)
  );

  pic_eoi_gen #(.DW(DW), .LW(LW)) u_eoi (
    .clk(clk), .rst_n(rst_n), .eoi_word_wr(eoi_word_wr), .wdata(wdata),
    .eoi_valid(eoi_valid), .eoi_specific(eoi_specific), .eoi_line(eoi_line)
  );

  pic_readback #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .sel_req(sel_req),
    .req_bits(req_bits), .isr_bits(isr_bits), .mask(mask_o), .rdata(rdata)
  );
endmodule

// File: rtl/pic_cmd_seq_chk.sv
module pic_cmd_seq_chk #(
  parameter int LW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 addr,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [(1<<LW)-1:0]   wdata,
  input logic [(1<<LW)-1:0]   rdata,
  input logic [(1<<LW)-1:0]   mask_o,
  input logic [(1<<LW)-1:0]   vec_base_o,
  input logic                 edge_mode_o,
  input logic                 auto_eoi_o,
  input logic                 eoi_valid
);
  assert_eoi_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |-> $past(wr_en && !addr && wdata[4:3] == 2'b00));

  assert_setup_clears_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (mask_o == '0));

  assert_vec_only_on_hi_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && addr) |-> $stable(vec_base_o));

  assert_auto_rise_on_hi_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(auto_eoi_o) |-> $past(wr_en && addr));

  assert_edge_only_on_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en && !addr && wdata[4]) |-> $stable(edge_mode_o));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> $stable(rdata));
endmodule

bind pic_cmd_seq pic_cmd_seq_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .mask_o(mask_o), .vec_base_o(vec_base_o),
  .edge_mode_o(edge_mode_o), .auto_eoi_o(auto_eoi_o), .eoi_valid(eoi_valid)
);

// File: tb/pic_cmd_seq_tb.sv
module pic_cmd_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] req_bits = 8'hA5, isr_bits = 8'h3C;
  logic [7:0] rdata, mask_o, vec_base_o, cascade_o;
  logic       edge_mode_o, single_mode_o, auto_eoi_o;
  logic       eoi_valid, eoi_specific;
  logic [2:0] eoi_line;
  logic [7:0] s_rdata, s_mask, s_vec, s_casc;
  logic       s_edge, s_single, s_auto, s_ev, s_es;
  logic [2:0] s_el;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pic_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .req_bits(req_bits), .isr_bits(isr_bits),
    .mask_o(mask_o), .vec_base_o(vec_base_o), .cascade_o(cascade_o),
    .edge_mode_o(edge_mode_o), .single_mode_o(single_mode_o),
    .auto_eoi_o(auto_eoi_o), .eoi_valid(eoi_valid),
    .eoi_specific(eoi_specific), .eoi_line(eoi_line)
  );

  pic_cmd_seq #(.IS_MASTER(1'b0)) slave_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(s_rdata), .req_bits(req_bits), .isr_bits(isr_bits),
    .mask_o(s_mask), .vec_base_o(s_vec), .cascade_o(s_casc),
    .edge_mode_o(s_edge), .single_mode_o(s_single), .auto_eoi_o(s_auto),
    .eoi_valid(s_ev), .eoi_specific(s_es), .eoi_line(s_el)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one write; returns at the negedge after the capturing edge.
  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    chk("R1 mask", mask_o, 8'h00);
    chk("R1 vec", vec_base_o, 8'h00);
    chk("R1 casc", cascade_o, 8'h00);
    chk("R1 flags", {5'b0, edge_mode_o, single_mode_o, auto_eoi_o}, 8'h00);
    chk("R1 eoi", {7'b0, eoi_valid}, 8'h00);
    rd(1'b0, r);
    chk("R1 R9 read selects request", r, 8'hA5);
  endtask

  task automatic t_idle_mask();
    logic [7:0] r;
    wr(1'b1, 8'h5A);
    chk("R6 mask load", mask_o, 8'h5A);
    rd(1'b1, r);
    chk("R9 read mask", r, 8'h5A);
  endtask

  task automatic t_single_setup();
    wr(1'b0, 8'h1A);
    chk("R2 mask cleared", mask_o, 8'h00);
    chk("R2 edge", {7'b0, edge_mode_o}, 8'h01);
    chk("R2 single", {7'b0, single_mode_o}, 8'h01);
    wr(1'b1, 8'h27);
    chk("R3 vec base", vec_base_o, 8'h20);
    chk("R3 single casc zero", cascade_o, 8'h00);
    wr(1'b1, 8'h0F);
    chk("R3 R6 setup ended, mask", mask_o, 8'h0F);
  endtask

  task automatic t_cascade_mode_byte();
    wr(1'b0, 8'h11);
    chk("R2 level", {7'b0, edge_mode_o}, 8'h00);
    chk("R2 cascade", {7'b0, single_mode_o}, 8'h00);
    wr(1'b1, 8'h48);
    chk("R3 vec base", vec_base_o, 8'h48);
    wr(1'b1, 8'h84);
    chk("R4 master casc", cascade_o, 8'h84);
    chk("R4 slave id", s_casc, 8'h04);
    chk("R5 mode byte pending keeps mask", mask_o, 8'h00);
    wr(1'b1, 8'h03);
    chk("R5 auto eoi set", {7'b0, auto_eoi_o}, 8'h01);
    wr(1'b1, 8'h77);
    chk("R5 R6 idle after mode byte", mask_o, 8'h77);
  endtask

  task automatic t_cascade_no_mode();
    wr(1'b0, 8'h10);
    chk("R2 auto cleared", {7'b0, auto_eoi_o}, 8'h00);
    chk("R2 mask cleared", mask_o, 8'h00);
    wr(1'b1, 8'h08);
    wr(1'b1, 8'hFF);
    chk("R4 master casc", cascade_o, 8'hFF);
    chk("R4 slave id", s_casc, 8'h07);
    wr(1'b1, 8'h12);
    chk("R5 ends after cascade", mask_o, 8'h12);
    chk("R5 auto stays off", {7'b0, auto_eoi_o}, 8'h00);
  endtask

  task automatic t_mode_ignored_bits();
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h1D);
    chk("R5 other bits ignored", {7'b0, auto_eoi_o}, 8'h00);
    wr(1'b1, 8'h3C);
    chk("R5 idle", mask_o, 8'h3C);
  endtask

  task automatic t_eoi();
    wr(1'b0, 8'h20);
    chk("R7 nonspec", {6'b0, eoi_valid, eoi_specific}, 8'h02);
    chk("R7 nonspec line", {5'b0, eoi_line}, 8'h00);
    @(negedge clk);
    chk("R7 one cycle", {7'b0, eoi_valid}, 8'h00);
    wr(1'b0, 8'h65);
    chk("R7 spec", {6'b0, eoi_valid, eoi_specific}, 8'h03);
    chk("R7 spec line", {5'b0, eoi_line}, 8'h05);
    wr(1'b0, 8'h40);
    chk("R7 noop 010", {7'b0, eoi_valid}, 8'h00);
    wr(1'b0, 8'hE3);
    chk("R7 noop 111", {7'b0, eoi_valid}, 8'h00);
    chk("R7 mask untouched", mask_o, 8'h3C);
  endtask

  task automatic t_readsel();
    logic [7:0] r;
    wr(1'b0, 8'h0A);
    rd(1'b0, r);
    chk("R8 select in-service", r, 8'h3C);
    wr(1'b0, 8'h09);
    rd(1'b0, r);
    chk("R8 bit1 clear keeps", r, 8'h3C);
    wr(1'b0, 8'h0B);
    req_bits = 8'h81;
    rd(1'b0, r);
    chk("R8 R9 select request", r, 8'h81);
    req_bits = 8'h00;
    @(negedge clk);
    chk("R9 holds without read", rdata, 8'h81);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle_mask();
        t_single_setup();
        t_cascade_mode_byte();
        t_cascade_no_mode();
        t_mode_ignored_bits();
        t_eoi();
        t_readsel();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule